// File: doc/BRIEF.md
# Indexed Host Register Port with Streaming Table Windows

This block sits between a 16-bit parallel host bus and the configuration state of a display controller. Every bus cycle carries a data/command select. A command cycle loads an 8-bit register index. A data cycle reads or writes the register that index points at, and the index then moves on by itself. Software can therefore program a run of registers with one command cycle followed by a burst of data cycles.

Three ports behave as streaming windows instead of plain registers. Two of them front internal byte tables: a gamma table with a wrapping pointer, and a filter-coefficient table with a pointer that saturates. Each has its own pointer register. The third is the pixel data port, which only holds the index, because pixel memory lies outside this block. The block also holds the masked configuration registers, the 10-bit coordinates that are split across low/high byte registers, and an interrupt status register whose bits are cleared by writing zero.

Accesses complete in a single cycle. An access strobe is classified as one of four kinds: index load, data write, data read, or peek. A peek is a read with the select line low. An idle cycle is classified as none. The index register takes one of three next-state paths: load, step by two, or step by one. It holds its value on a peek, on an idle cycle, and on a write to a streaming port.

Top module: `hostreg_port`

## Requirements
- R1: A strobed write cycle with select low loads the register index from bus bits 7:0 and changes no register.
- R2: A data write (select high) at any index other than 0x5a, 0x90 or 0xb8 advances the index by 2, modulo 256. This includes unknown indices.
- R3: A data write at 0x5a (filter data), 0x90 (pixel port) or 0xb8 (gamma data) leaves the index unchanged.
- R4: A data read returns the indexed value on bus_rdata from the cycle after the strobe, with bits 15:8 zero, and advances the index by 1. A peek (read with select low) returns the same value with no index step and no pointer step.
- R5: A write to a plain register stores bus bits 7:0 AND that register's mask. Masks: 0x04→0x3f, 0x06→0x03, 0x0e→0xff, 0x24→0x01, 0x2a→0xff, 0x56→0xbf, 0x68→0xb7, 0x6a→0xfb, 0x8c→0x0f, 0xb4→0x87, 0xe6→0x83, 0xe8→0x1b.
- R6: Fixed and decorated readback. 0x00 reads 0xa5 and 0x02 reads 0x83. 0x04 reads its stored 6-bit count with bit 7 set. 0xe8 reads its stored value with bit 5 set.
- R7: Gamma table. A write to 0xb6 sets the 8-bit pointer, and reading 0xb6 returns it. A write or a data read at 0xb8 accesses entry [pointer] and then increments the pointer, wrapping 0xff→0x00.
- R8: Filter table. A write to 0x58 keeps only bits 4:0, and reading 0x58 returns the pointer (0..32). A write or a data read at 0x5a accesses entry [pointer] and then increments it. At pointer 32, writes are ignored, reads return 0, and the pointer stays at 32.
- R9: 10-bit values. The low register (0x2e, and 0x6c+4k for k=0..7) writes bits 7:0 and keeps bits 9:8. The high register (low+2) writes bits 9:8 from bus bits 1:0, keeps bits 7:0, and reads back bits 9:8 in bits 1:0.
- R10: Interrupt status at 0xf6. A bit is set by a pulse on irq_event. A write leaves status AND data. A set arriving in the same cycle as a clear wins.
- R11: Unknown indices and the pixel port read 0, and writes to them change nothing.
- R12: Reset sets the index to 0, both pointers and both tables to 0, and status to 0. Non-zero defaults: 0x04 count 8, 0x06=1, 0x2a=1, height (0x2e/0x30)=1, 0x56=0x80, 0x8c=3, 0xe6=2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Access strobe, one access per cycle |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_dc | input | 1 | 1 = data cycle, 0 = command cycle |
| bus_wdata | input | DATA_W | Write data or index |
| irq_event | input | IRQ_W | Interrupt status set pulses |
| bus_rdata | output | DATA_W | Read data, registered |

## Verification
The bench builds the block with its defaults: a 256-entry gamma table with an 8-bit pointer, a 32-entry filter table with a 6-bit pointer, and 10-bit coordinates. With these values the gamma wrap from 0xff to 0x00 and the filter saturation at entry 32 are each reached within a handful of accesses. Both bits of every coordinate's high field are also exercised. Long random bursts then mix index loads, writes, reads, peeks and status pulses, so stepping across streaming and plain ports is observed together with the index wrapping past 0xff.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
    localparam int IDX_W = 8;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_INDEX,
        ACC_WRITE,
        ACC_READ,
        ACC_PEEK
    } acc_kind_e;

    localparam logic [7:0] A_REV   = 8'h00;
    localparam logic [7:0] A_CFG   = 8'h02;
    localparam logic [7:0] A_DIV   = 8'h04;
    localparam logic [7:0] A_FIDX  = 8'h58;
    localparam logic [7:0] A_FDATA = 8'h5a;
    localparam logic [7:0] A_PIX   = 8'h90;
    localparam logic [7:0] A_GIDX  = 8'hb6;
    localparam logic [7:0] A_GDATA = 8'hb8;
    localparam logic [7:0] A_NDP   = 8'he8;
    localparam logic [7:0] A_IRQ   = 8'hf6;

    localparam logic [7:0] REV_VALUE = 8'ha5;
    localparam logic [7:0] CFG_VALUE = 8'h83;
    localparam logic [7:0] DIV_FLAG  = 8'h80;
    localparam logic [7:0] NDP_FLAG  = 8'h20;

    localparam int N_PLAIN = 12;
    localparam logic [7:0] PLAIN_ADDR [N_PLAIN] = '{
        8'h04, 8'h06, 8'h0e, 8'h24, 8'h2a, 8'h56,
        8'h68, 8'h6a, 8'h8c, 8'hb4, 8'he6, 8'he8};
    localparam logic [7:0] PLAIN_MASK [N_PLAIN] = '{
        8'h3f, 8'h03, 8'hff, 8'h01, 8'hff, 8'hbf,
        8'hb7, 8'hfb, 8'h0f, 8'h87, 8'h83, 8'h1b};
    localparam logic [7:0] PLAIN_RST  [N_PLAIN] = '{
        8'h08, 8'h01, 8'h00, 8'h00, 8'h01, 8'h80,
        8'h00, 8'h00, 8'h03, 8'h00, 8'h02, 8'h00};

    localparam int N_COORD = 9;
    localparam logic [7:0] COORD_LO [N_COORD] = '{
        8'h2e, 8'h6c, 8'h70, 8'h74, 8'h78, 8'h7c, 8'h80, 8'h84, 8'h88};
    localparam logic [15:0] COORD_RST [N_COORD] = '{
        16'd1, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0};
endpackage

// File: rtl/hrp_split_reg.sv
module hrp_split_reg #(
    parameter int W = 10,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [7:0]   wbyte,
    output logic [W-1:0] value
);
    localparam int HI_W = W - 8;

    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST;
        end else begin
            if (wr_lo) q[7:0] <= wbyte;
            if (wr_hi) q[W-1:8] <= wbyte[HI_W-1:0];
        end
    end

    assign value = q;

    // R9: a low-byte write must leave the upper field untouched
    assert_lo_keeps_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> (value[W-1:8] == $past(value[W-1:8])));
    // R9: a high-byte write must leave the low byte untouched
    assert_hi_keeps_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> (value[7:0] == $past(value[7:0])));
endmodule

// File: rtl/hrp_stream_table.sv
module hrp_stream_table #(
    parameter int DEPTH = 32,
    parameter bit SATURATE = 1'b1,
    parameter int AW = $clog2(DEPTH),
    parameter int PTR_W = SATURATE ? AW + 1 : AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_load,
    input  logic [PTR_W-1:0] ptr_wdata,
    input  logic             wr,
    input  logic             rd,
    input  logic [7:0]       wbyte,
    output logic [7:0]       rbyte,
    output logic [PTR_W-1:0] ptr
);
    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] ptr_q;
    logic             in_range;
    logic [AW-1:0]    slot;

    generate
        if (SATURATE) begin : g_sat
            assign in_range = ({1'b0, ptr_q} < (PTR_W+1)'(DEPTH));
        end else begin : g_wrap
            assign in_range = 1'b1;
        end
    endgenerate

    assign slot = ptr_q[AW-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_load) begin
            ptr_q <= ptr_wdata;
        end else if ((wr || rd) && in_range) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= 8'h00;
        end else if (wr && in_range) begin
            mem[slot] <= wbyte;
        end
    end

    assign rbyte = in_range ? mem[slot] : 8'h00;
    assign ptr   = ptr_q;

    generate
        if (SATURATE) begin : g_sat_chk
            // R8: accesses below the end step the pointer by one
            assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
                ((wr || rd) && !ptr_load && ({1'b0, ptr} < (PTR_W+1)'(DEPTH)))
                |=> (ptr == $past(ptr) + 1'b1));
            // R8: at the end the pointer holds and reads give zero
            assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
                ((wr || rd) && !ptr_load && ({1'b0, ptr} >= (PTR_W+1)'(DEPTH)))
                |=> $stable(ptr));
        end else begin : g_wrap_chk
            // R7: each access steps the pointer, wrapping at its width
            assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
                ((wr || rd) && !ptr_load) |=> (ptr == $past(ptr) + 1'b1));
        end
    endgenerate
endmodule

// File: rtl/hrp_irq_status.sv
module hrp_irq_status #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_wr,
    input  logic [W-1:0] keep,
    input  logic [W-1:0] set_evt,
    output logic [W-1:0] status
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (clr_wr ? (q & keep) : q) | set_evt;
    end

    assign status = q;

    // R10: every pulsed bit is set in the following cycle
    assert_irq_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_evt) |=> ((status & $past(set_evt)) == $past(set_evt)));
    // R10: a zero written to a bit with no concurrent set clears it
    assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((status & ~$past(keep) & ~$past(set_evt)) == '0));
endmodule

// File: rtl/hostreg_port.sv
module hostreg_port
    import hrp_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int GAMMA_DEPTH = 256,
    parameter int FILT_DEPTH  = 32,
    parameter int COORD_W     = 10,
    parameter int IRQ_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_rd,
    input  logic              bus_dc,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [IRQ_W-1:0]  irq_event,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int GAW    = $clog2(GAMMA_DEPTH);
    localparam int FAW    = $clog2(FILT_DEPTH);
    localparam int GPTR_W = GAW;
    localparam int FPTR_W = FAW + 1;

    acc_kind_e          acc;
    logic [IDX_W-1:0]   idx_q;
    logic [7:0]         wbyte;
    logic               wdata_unused_hi;
    logic               wr_en;
    logic               rd_en;
    logic               at_stream;
    logic [7:0]         rd_val;
    logic [7:0]         plain_q [N_PLAIN];
    logic [COORD_W-1:0] coord_q [N_COORD];
    logic [7:0]         gam_rbyte;
    logic [7:0]         fil_rbyte;
    logic [GPTR_W-1:0]  gam_ptr;
    logic [FPTR_W-1:0]  fil_ptr;
    logic [IRQ_W-1:0]   irq_q;

    assign wbyte           = bus_wdata[7:0];
    assign wdata_unused_hi = ^bus_wdata[DATA_W-1:8];

    // access classification
    always_comb begin
        acc = ACC_NONE;
        if (bus_cs) begin
            unique case ({bus_dc, bus_rd})
                2'b00: acc = ACC_INDEX;
                2'b01: acc = ACC_PEEK;
                2'b10: acc = ACC_WRITE;
                2'b11: acc = ACC_READ;
            endcase
        end
    end

    assign wr_en     = (acc == ACC_WRITE);
    assign rd_en     = (acc == ACC_READ);
    assign at_stream = (idx_q == A_FDATA) || (idx_q == A_PIX) || (idx_q == A_GDATA);

    // index register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            unique case (acc)
                ACC_INDEX: idx_q <= wbyte;
                ACC_WRITE: if (!at_stream) idx_q <= idx_q + 8'd2;
                ACC_READ:  idx_q <= idx_q + 8'd1;
                default:   ;
            endcase
        end
    end

    // plain masked registers
    generate
        for (genvar i = 0; i < N_PLAIN; i++) begin : g_plain
            logic [7:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n) q <= PLAIN_RST[i];
                else if (wr_en && (idx_q == PLAIN_ADDR[i])) q <= wbyte & PLAIN_MASK[i];
            end
            assign plain_q[i] = q;
        end
    endgenerate

    // split 10-bit values
    generate
        for (genvar c = 0; c < N_COORD; c++) begin : g_coord
            logic [COORD_W-1:0] v;
            hrp_split_reg #(
                .W   (COORD_W),
                .RST (COORD_W'(COORD_RST[c]))
            ) u_split (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_lo (wr_en && (idx_q == COORD_LO[c])),
                .wr_hi (wr_en && (idx_q == COORD_LO[c] + 8'd2)),
                .wbyte (wbyte),
                .value (v)
            );
            assign coord_q[c] = v;
        end
    endgenerate

    // streaming tables
    hrp_stream_table #(
        .DEPTH    (GAMMA_DEPTH),
        .SATURATE (1'b0)
    ) u_gamma (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_load  (wr_en && (idx_q == A_GIDX)),
        .ptr_wdata (bus_wdata[GPTR_W-1:0]),
        .wr        (wr_en && (idx_q == A_GDATA)),
        .rd        (rd_en && (idx_q == A_GDATA)),
        .wbyte     (wbyte),
        .rbyte     (gam_rbyte),
        .ptr       (gam_ptr)
    );

    hrp_stream_table #(
        .DEPTH    (FILT_DEPTH),
        .SATURATE (1'b1)
    ) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_load  (wr_en && (idx_q == A_FIDX)),
        .ptr_wdata (FPTR_W'(bus_wdata[FAW-1:0])),
        .wr        (wr_en && (idx_q == A_FDATA)),
        .rd        (rd_en && (idx_q == A_FDATA)),
        .wbyte     (wbyte),
        .rbyte     (fil_rbyte),
        .ptr       (fil_ptr)
    );

    // interrupt status
    hrp_irq_status #(
        .W (IRQ_W)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_wr  (wr_en && (idx_q == A_IRQ)),
        .keep    (bus_wdata[IRQ_W-1:0]),
        .set_evt (irq_event),
        .status  (irq_q)
    );

    // read multiplexer
    always_comb begin
        rd_val = 8'h00;
        for (int i = 0; i < N_PLAIN; i++) begin
            if (idx_q == PLAIN_ADDR[i]) rd_val = plain_q[i];
        end
        for (int c = 0; c < N_COORD; c++) begin
            if (idx_q == COORD_LO[c])         rd_val = coord_q[c][7:0];
            if (idx_q == COORD_LO[c] + 8'd2)  rd_val = 8'(coord_q[c][COORD_W-1:8]);
        end
        unique case (idx_q)
            A_REV:   rd_val = REV_VALUE;
            A_CFG:   rd_val = CFG_VALUE;
            A_DIV:   rd_val = rd_val | DIV_FLAG;
            A_NDP:   rd_val = rd_val | NDP_FLAG;
            A_FIDX:  rd_val = 8'(fil_ptr);
            A_FDATA: rd_val = fil_rbyte;
            A_GIDX:  rd_val = 8'(gam_ptr);
            A_GDATA: rd_val = gam_rbyte;
            A_IRQ:   rd_val = 8'(irq_q);
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if ((acc == ACC_READ) || (acc == ACC_PEEK)) begin
            bus_rdata <= DATA_W'(rd_val);
        end
    end

    // R1: an index cycle loads the bus low byte
    assert_index_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && !bus_dc && !bus_rd) |=> (idx_q == $past(bus_wdata[7:0])));
    // R2: ordinary data writes step by two
    assert_write_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_dc && !bus_rd && !at_stream) |=> (idx_q == $past(idx_q) + 8'd2));
    // R3: streaming ports hold the index on writes
    assert_stream_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_dc && !bus_rd && at_stream) |=> $stable(idx_q));
    // R4: data reads step by one, peeks hold
    assert_read_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_dc && bus_rd) |=> (idx_q == $past(idx_q) + 8'd1));
    assert_peek_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && !bus_dc && bus_rd) |=> $stable(idx_q));
    // R6: the revision register returns its constant
    assert_rev_const_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_rd && (idx_q == A_REV)) |=> (bus_rdata == DATA_W'(REV_VALUE)));
endmodule

// File: tb/hostreg_port_bench.sv
`timescale 1ns/1ps
module hostreg_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_dc = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [7:0]  irq_event = '0;
    logic [15:0] bus_rdata;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [7:0] m_reg [256];
    logic [7:0] m_gam [256];
    logic [7:0] m_fil [32];
    int         m_fp;
    logic [7:0] m_gp;
    logic [7:0] m_irq;
    logic [7:0] m_idx;

    hostreg_port u_hostreg_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_cs    (bus_cs),
        .bus_rd    (bus_rd),
        .bus_dc    (bus_dc),
        .bus_wdata (bus_wdata),
        .irq_event (irq_event),
        .bus_rdata (bus_rdata)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] mask_of(input logic [7:0] a);
        case (a)
            8'h04: return 8'h3f;  8'h06: return 8'h03;  8'h0e: return 8'hff;
            8'h24: return 8'h01;  8'h2a: return 8'hff;  8'h56: return 8'hbf;
            8'h68: return 8'hb7;  8'h6a: return 8'hfb;  8'h8c: return 8'h0f;
            8'hb4: return 8'h87;  8'he6: return 8'h83;  8'he8: return 8'h1b;
            8'h2e: return 8'hff;  8'h30: return 8'h03;
            default: begin
                if (a >= 8'h6c && a <= 8'h8a && a[0] == 1'b0)
                    return (a[1] == 1'b0) ? 8'hff : 8'h03;
                return 8'h00;
            end
        endcase
    endfunction

    function automatic bit is_coord(input logic [7:0] a);
        return (a == 8'h2e) || (a == 8'h30) || (a >= 8'h6c && a <= 8'h8a && a[0] == 1'b0);
    endfunction

    function automatic string req_of(input logic [7:0] a);
        if (a == 8'h00 || a == 8'h02 || a == 8'h04 || a == 8'he8) return "R6";
        if (a == 8'h58 || a == 8'h5a) return "R8";
        if (a == 8'hb6 || a == 8'hb8) return "R7";
        if (a == 8'hf6) return "R10";
        if (is_coord(a)) return "R9";
        if (mask_of(a) != 8'h00) return "R5";
        return "R11";
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00: return 8'ha5;
            8'h02: return 8'h83;
            8'h04: return m_reg[a] | 8'h80;
            8'he8: return m_reg[a] | 8'h20;
            8'h58: return 8'(m_fp);
            8'h5a: return (m_fp < 32) ? m_fil[m_fp] : 8'h00;
            8'hb6: return m_gp;
            8'hb8: return m_gam[m_gp];
            8'hf6: return m_irq;
            default: return (mask_of(a) != 8'h00) ? m_reg[a] : 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] pick(input int n);
        case (n % 30)
            0: return 8'h00;   1: return 8'h02;   2: return 8'h04;   3: return 8'h06;
            4: return 8'h0e;   5: return 8'h24;   6: return 8'h2a;   7: return 8'h2e;
            8: return 8'h30;   9: return 8'h56;  10: return 8'h58;  11: return 8'h5a;
            12: return 8'h68; 13: return 8'h6a;  14: return 8'h6c;  15: return 8'h6e;
            16: return 8'h7a; 17: return 8'h8a;  18: return 8'h8c;  19: return 8'h90;
            20: return 8'hb4; 21: return 8'hb6;  22: return 8'hb8;  23: return 8'he6;
            24: return 8'he8; 25: return 8'hf6;  26: return 8'hfe;  27: return 8'h03;
            28: return 8'h78; default: return 8'h84;
        endcase
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 256; k++) begin m_reg[k] = 8'h00; m_gam[k] = 8'h00; end
        for (int k = 0; k < 32; k++) m_fil[k] = 8'h00;
        m_reg[8'h04] = 8'h08; m_reg[8'h06] = 8'h01; m_reg[8'h2a] = 8'h01;
        m_reg[8'h2e] = 8'h01; m_reg[8'h56] = 8'h80; m_reg[8'h8c] = 8'h03;
        m_reg[8'he6] = 8'h02;
        m_fp = 0; m_gp = 8'h00; m_irq = 8'h00; m_idx = 8'h00;
    endtask

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic cycle(input bit rd, input bit dc, input logic [15:0] d,
                         input logic [7:0] ev, input string tag);
        logic [7:0] cur;
        logic [7:0] exp;
        @(negedge clk);
        bus_cs = 1'b1; bus_rd = rd; bus_dc = dc; bus_wdata = d; irq_event = ev;
        cur = m_idx;
        exp = exp_read(cur);
        @(negedge clk);
        bus_cs = 1'b0; irq_event = 8'h00;
        if (rd) check((tag == "") ? req_of(cur) : tag, bus_rdata, {8'h00, exp});
        if (!dc && !rd) begin
            m_idx = d[7:0];
        end else if (dc && !rd) begin
            if (mask_of(cur) != 8'h00) m_reg[cur] = d[7:0] & mask_of(cur);
            else if (cur == 8'h58) m_fp = int'(d[4:0]);
            else if (cur == 8'hb6) m_gp = d[7:0];
            else if (cur == 8'h5a) begin
                if (m_fp < 32) begin m_fil[m_fp] = d[7:0]; m_fp++; end
            end else if (cur == 8'hb8) begin
                m_gam[m_gp] = d[7:0]; m_gp = m_gp + 8'd1;
            end else if (cur == 8'hf6) m_irq = m_irq & d[7:0];
            if (cur != 8'h5a && cur != 8'h90 && cur != 8'hb8) m_idx = m_idx + 8'd2;
        end else if (dc && rd) begin
            if (cur == 8'h5a && m_fp < 32) m_fp++;
            if (cur == 8'hb8) m_gp = m_gp + 8'd1;
            m_idx = m_idx + 8'd1;
        end
        m_irq = m_irq | ev;
    endtask

    task automatic set_idx(input logic [7:0] a);
        cycle(1'b0, 1'b0, {8'h00, a}, 8'h00, "");
    endtask
    task automatic wr(input logic [15:0] d);
        cycle(1'b0, 1'b1, d, 8'h00, "");
    endtask
    task automatic rd(input string tag);
        cycle(1'b1, 1'b1, 16'h0000, 8'h00, tag);
    endtask
    task automatic peek(input string tag);
        cycle(1'b1, 1'b0, 16'h0000, 8'h00, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_cs = 1'b0; irq_event = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic reset_sweep();
        peek("R12");
        for (int n = 0; n < 30; n++) begin
            set_idx(pick(n));
            peek("R12");
        end
    endtask

    initial begin
        logic [31:0] r;
        r = $urandom(32'h5eed_1234);
        do_reset();
        reset_sweep();

        // R1: index load
        set_idx(8'h24); wr(16'h00ff); set_idx(8'h24); peek("R1");
        // R2: step by two across registers, and wrap past 0xff
        set_idx(8'h68); wr(16'h1234); wr(16'hffff); set_idx(8'h6a); peek("R2");
        set_idx(8'h68); peek("R2");
        set_idx(8'hfe); wr(16'h00aa); peek("R2");
        set_idx(8'h10); wr(16'h0077); wr(16'h0055); set_idx(8'h12); peek("R2");
        // R4: read stepping and peek holding
        set_idx(8'h00); rd("R4"); rd("R4"); rd("R4"); peek("R4"); peek("R4");
        // R5: mask on a full-width write
        set_idx(8'h8c); wr(16'hffff); set_idx(8'h8c); peek("R5");
        // R3 and R7: gamma stream holds index, pointer wraps
        set_idx(8'hb6); wr(16'h00fe);
        set_idx(8'hb8); wr(16'h0011); wr(16'h0022); wr(16'h0033);
        set_idx(8'hb6); peek("R7");
        set_idx(8'hb6); wr(16'h00fe); set_idx(8'hb8); rd("R3");
        set_idx(8'hb8); rd("R7"); set_idx(8'hb8); rd("R7");
        set_idx(8'h90); wr(16'h5555); wr(16'h6666); peek("R3");
        // R8: filter index masking and saturation
        set_idx(8'h58); wr(16'h003e); set_idx(8'h58); peek("R8");
        set_idx(8'h5a); wr(16'h00a1); wr(16'h00b2); wr(16'h00c3);
        set_idx(8'h58); peek("R8");
        set_idx(8'h5a); rd("R8");
        set_idx(8'h58); wr(16'h001f); set_idx(8'h5a); rd("R8");
        set_idx(8'h58); peek("R8");
        // R9: split 10-bit coordinate
        set_idx(8'h6c); wr(16'h01ab); wr(16'h00ff);
        set_idx(8'h6c); wr(16'h0012);
        set_idx(8'h6e); peek("R9"); set_idx(8'h6c); peek("R9");
        set_idx(8'h30); wr(16'h0002); set_idx(8'h2e); peek("R9"); set_idx(8'h30); peek("R9");
        // R10: set, clear, and set winning over clear
        cycle(1'b0, 1'b0, 16'h00f6, 8'h0f, "");
        peek("R10");
        cycle(1'b0, 1'b1, 16'h0005, 8'h20, "");
        set_idx(8'hf6); peek("R10");
        cycle(1'b0, 1'b1, 16'h0000, 8'h01, "");
        set_idx(8'hf6); peek("R10");
        // R11: unknown and pixel ports
        set_idx(8'h92); wr(16'hffff); set_idx(8'h92); peek("R11");
        set_idx(8'h90); peek("R11");
        // R6: decorated readback
        set_idx(8'h04); wr(16'hffff); set_idx(8'h04); peek("R6");
        set_idx(8'he8); wr(16'hffff); set_idx(8'he8); peek("R6");

        // random mix
        for (int t = 0; t < 4000; t++) begin
            int op;
            logic [7:0] ev;
            op = int'($urandom_range(0, 99));
            ev = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h00;
            if (op < 25) begin
                if ($urandom_range(0, 4) == 0) cycle(1'b0, 1'b0, 16'($urandom), ev, "");
                else cycle(1'b0, 1'b0, {8'($urandom), pick(int'($urandom_range(0, 29)))}, ev, "");
            end else if (op < 60) cycle(1'b0, 1'b1, 16'($urandom), ev, "");
            else if (op < 90) cycle(1'b1, 1'b1, 16'h0000, ev, "");
            else cycle(1'b1, 1'b0, 16'h0000, ev, "");
        end

        // R12: reset after traffic
        do_reset();
        reset_sweep();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule